// File: doc/BRIEF.md
# Processor status word with banked stack pointers

This block holds a 16-bit processor status word and a bank of three stack-pointer registers: user, interrupt and master. It shows the rest of the core one architectural stack pointer. The supervisor bit S (bit 13) and the master bit M (bit 12) of the status word choose which bank slot is live. When a status-word write changes the mode, the live pointer is saved into the slot of the old mode. In the same clock edge, the slot of the new mode is loaded as the live pointer.

A model-select input picks which status bits are writable. The basic model implements only the bits in mask 0xA71F, so T0 (bit 14) and M read as zero. In the basic model the master slot can therefore never be selected through the status word. The extended model implements mask 0xF71F.

Each slot can also be read and written directly. Such an access goes to the live pointer when the addressed slot is the active one, and to the stored copy otherwise. Two 3-bit function-code registers, one for source and one for destination, sit beside the status word.

All writes take effect at the rising clock edge. All read ports are combinational views of the registered state.

Top module: `psw_spbank`

## Requirements
- R1: On a synchronous reset the status word reads 0x2000 (S=1, M=0). The architectural pointer, every slot and both function-code registers read zero.
- R2: With `model_ext`=0, a status-word write stores `sr_wdata & 0xA71F`. Bits outside that mask read back as zero, including T0 (bit 14) and M (bit 12).
- R3: With `model_ext`=1, a status-word write stores `sr_wdata & 0xF71F`.
- R4: Slot encoding is 0 = user, 1 = interrupt, 2 = master. The architectural pointer `sp_q` is slot 0 when S=0, slot 1 when S=1 and M=0, and slot 2 when S=1 and M=1.
- R5: A status-word write that changes the selected slot does two things in the same edge. It stores the live pointer into the old slot, and it makes the new slot's stored value the live pointer.
- R6: A direct slot read or write whose `bank_sel` equals the active slot reads or writes the live pointer.
- R7: A direct slot access to an inactive slot reads or writes only that slot's stored copy. It leaves `sp_q` unchanged.
- R8: When `sp_we` and a direct write to the active slot occur in the same cycle, `sp_wdata` wins. When `sp_we` coincides with a mode change, `sp_wdata` is the value saved into the old slot.
- R9: The source and destination function-code registers keep only bits 2..0 of `fc_wdata`, and each is written only by its own enable.
- R10: `bank_sel`=3 reads zero, and a direct write with `bank_sel`=3 changes no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| model_ext | input | 1 | 0 = basic writable mask, 1 = extended mask |
| sr_we | input | 1 | Status-word write enable |
| sr_wdata | input | 16 | Status-word write data |
| sr_q | output | 16 | Current status word |
| sp_we | input | 1 | Architectural stack-pointer write enable |
| sp_wdata | input | 32 | Architectural stack-pointer write data |
| sp_q | output | 32 | Architectural (live) stack pointer |
| bank_sel | input | 2 | Direct slot select (0 user, 1 interrupt, 2 master) |
| bank_we | input | 1 | Direct slot write enable |
| bank_wdata | input | 32 | Direct slot write data |
| bank_rdata | output | 32 | Direct slot read data |
| fcs_we | input | 1 | Source function-code write enable |
| fcd_we | input | 1 | Destination function-code write enable |
| fc_wdata | input | 32 | Function-code write data |
| fcs_q | output | 3 | Source function code |
| fcd_q | output | 3 | Destination function code |

## Verification
The in-RTL properties check the following on every cycle:
- the status word is masked on each write and holds between writes;
- a mode change with no competing write saves the live pointer and loads the new slot;
- the live pointer holds when nothing addresses it;
- an out-of-range select writes nothing;
- each function-code register captures its low three bits.

Only the bench's scenarios can show the cross-effects. These are where a direct write lands relative to the active mode, `sp_we` overriding a direct write in the same cycle, a write to the target slot in the same edge as a swap, and slot contents surviving several mode round trips. The bench compares these against a reference model after every operation.

// File: rtl/psw_spbank_pkg.sv
package psw_spbank_pkg;

    localparam int SR_W   = 16;
    localparam int FC_W   = 3;
    localparam int NSLOT  = 3;
    localparam int SEL_W  = 2;

    localparam int BIT_S  = 13;
    localparam int BIT_M  = 12;

    localparam logic [SR_W-1:0] MASK_BASIC = 16'hA71F;
    localparam logic [SR_W-1:0] MASK_EXT   = 16'hF71F;
    localparam logic [SR_W-1:0] SR_RESET   = 16'h2000;

    typedef enum logic [SEL_W-1:0] {
        SLOT_USR = 2'd0,
        SLOT_INT = 2'd1,
        SLOT_MST = 2'd2,
        SLOT_NONE = 2'd3
    } slot_e;

    typedef struct packed {
        logic       s;
        logic       m;
    } priv_t;

    function automatic logic [SR_W-1:0] wr_mask(input logic ext);
        return ext ? MASK_EXT : MASK_BASIC;
    endfunction

    function automatic priv_t priv_of(input logic [SR_W-1:0] sr);
        priv_t p;
        p.s = sr[BIT_S];
        p.m = sr[BIT_M];
        return p;
    endfunction

    function automatic slot_e slot_of(input logic [SR_W-1:0] sr);
        priv_t p;
        p = priv_of(sr);
        if (!p.s)
            return SLOT_USR;
        else if (p.m)
            return SLOT_MST;
        else
            return SLOT_INT;
    endfunction

endpackage

// File: rtl/psw_status.sv
module psw_status
    import psw_spbank_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            model_ext,
    input  logic            sr_we,
    input  logic [SR_W-1:0] sr_wdata,
    output logic [SR_W-1:0] sr_q,
    output slot_e           cur_slot,
    output slot_e           nxt_slot
);

    logic [SR_W-1:0] sr_r;
    logic [SR_W-1:0] sr_masked;

    always_comb begin
        sr_masked = sr_wdata & wr_mask(model_ext);
        cur_slot  = slot_of(sr_r);
        nxt_slot  = sr_we ? slot_of(sr_masked) : slot_of(sr_r);
    end

    always_ff @(posedge clk) begin
        if (rst)
            sr_r <= SR_RESET;
        else if (sr_we)
            sr_r <= sr_masked;
    end

    assign sr_q = sr_r;

    p_basic_mask_r2: assert property (@(posedge clk) disable iff (rst)
        (sr_we && !model_ext) |=> ((sr_q & ~MASK_BASIC) == '0));

    p_ext_mask_r3: assert property (@(posedge clk) disable iff (rst)
        (sr_we && model_ext) |=> (sr_q == ($past(sr_wdata) & MASK_EXT)));

    p_sr_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !sr_we |=> $stable(sr_q));

endmodule

// File: rtl/psw_sp_bank.sv
module psw_sp_bank
    import psw_spbank_pkg::*;
#(
    parameter int DW = 32
)(
    input  logic          clk,
    input  logic          rst,
    input  slot_e         cur_slot,
    input  slot_e         nxt_slot,
    input  logic          sp_we,
    input  logic [DW-1:0] sp_wdata,
    output logic [DW-1:0] sp_q,
    input  logic [SEL_W-1:0] bank_sel,
    input  logic          bank_we,
    input  logic [DW-1:0] bank_wdata,
    output logic [DW-1:0] bank_rdata
);

    logic [DW-1:0] live_r;
    logic [DW-1:0] live_mid;
    logic [DW-1:0] live_nx;
    logic [DW-1:0] slot_r   [NSLOT];
    logic [DW-1:0] slot_mid [NSLOT];
    logic [DW-1:0] slot_nx  [NSLOT];
    logic          sel_ok;
    logic          sel_live;
    logic          swap;

    always_comb begin
        sel_ok   = (bank_sel < SEL_W'(NSLOT));
        sel_live = sel_ok && (bank_sel == cur_slot);
        swap     = (nxt_slot != cur_slot);

        // direct write, then architectural write on top of it
        live_mid = live_r;
        if (bank_we && sel_live)
            live_mid = bank_wdata;
        if (sp_we)
            live_mid = sp_wdata;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NSLOT; gi++) begin : g_slot
            always_comb begin
                slot_mid[gi] = slot_r[gi];
                if (bank_we && sel_ok && !sel_live && (bank_sel == SEL_W'(gi)))
                    slot_mid[gi] = bank_wdata;
                slot_nx[gi] = slot_mid[gi];
                if (swap && (cur_slot == slot_e'(gi)))
                    slot_nx[gi] = live_mid;
            end

            always_ff @(posedge clk) begin
                if (rst)
                    slot_r[gi] <= '0;
                else
                    slot_r[gi] <= slot_nx[gi];
            end
        end
    endgenerate

    always_comb begin
        live_nx = live_mid;
        if (swap && (nxt_slot != SLOT_NONE))
            live_nx = slot_mid[nxt_slot];
    end

    always_ff @(posedge clk) begin
        if (rst)
            live_r <= '0;
        else
            live_r <= live_nx;
    end

    always_comb begin
        if (sel_live)
            bank_rdata = live_r;
        else if (sel_ok)
            bank_rdata = slot_r[bank_sel];
        else
            bank_rdata = '0;
    end

    assign sp_q = live_r;

    p_swap_load_r5: assert property (@(posedge clk) disable iff (rst)
        (cur_slot != nxt_slot && !sp_we && !bank_we) |=> (sp_q == $past(slot_r[nxt_slot])));

    p_swap_save_r5: assert property (@(posedge clk) disable iff (rst)
        (cur_slot != nxt_slot && !bank_we) |=> (slot_r[$past(cur_slot)] == $past(live_mid)));

    p_live_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (cur_slot == nxt_slot && !sp_we && !(bank_we && bank_sel == cur_slot)) |=> $stable(sp_q));

    p_sp_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (sp_we && cur_slot == nxt_slot) |=> (sp_q == $past(sp_wdata)));

    p_sel3_nowrite_r10: assert property (@(posedge clk) disable iff (rst)
        (bank_we && bank_sel == SLOT_NONE && !sp_we && cur_slot == nxt_slot)
            |=> ($stable(sp_q) && $stable(slot_r[0]) && $stable(slot_r[1]) && $stable(slot_r[2])));

endmodule

// File: rtl/psw_fc_regs.sv
module psw_fc_regs
    import psw_spbank_pkg::*;
#(
    parameter int DW  = 32,
    parameter int NFC = 2
)(
    input  logic            clk,
    input  logic            rst,
    input  logic [NFC-1:0]  we,
    input  logic [DW-1:0]   wdata,
    output logic [FC_W-1:0] q [NFC]
);

    genvar gi;
    generate
        for (gi = 0; gi < NFC; gi++) begin : g_fc
            logic [FC_W-1:0] fc_r;
            always_ff @(posedge clk) begin
                if (rst)
                    fc_r <= '0;
                else if (we[gi])
                    fc_r <= wdata[FC_W-1:0];
            end
            assign q[gi] = fc_r;

            p_fc_low_r9: assert property (@(posedge clk) disable iff (rst)
                we[gi] |=> (q[gi] == $past(wdata[FC_W-1:0])));

            p_fc_hold_r9: assert property (@(posedge clk) disable iff (rst)
                !we[gi] |=> $stable(q[gi]));
        end
    endgenerate

endmodule

// File: rtl/psw_spbank.sv
module psw_spbank
    import psw_spbank_pkg::*;
#(
    parameter int DW = 32
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            model_ext,
    input  logic            sr_we,
    input  logic [SR_W-1:0] sr_wdata,
    output logic [SR_W-1:0] sr_q,
    input  logic            sp_we,
    input  logic [DW-1:0]   sp_wdata,
    output logic [DW-1:0]   sp_q,
    input  logic [SEL_W-1:0] bank_sel,
    input  logic            bank_we,
    input  logic [DW-1:0]   bank_wdata,
    output logic [DW-1:0]   bank_rdata,
    input  logic            fcs_we,
    input  logic            fcd_we,
    input  logic [DW-1:0]   fc_wdata,
    output logic [FC_W-1:0] fcs_q,
    output logic [FC_W-1:0] fcd_q
);

    slot_e           cur_slot;
    slot_e           nxt_slot;
    logic [FC_W-1:0] fc_q [2];

    psw_status u_status (
        .clk      (clk),
        .rst      (rst),
        .model_ext(model_ext),
        .sr_we    (sr_we),
        .sr_wdata (sr_wdata),
        .sr_q     (sr_q),
        .cur_slot (cur_slot),
        .nxt_slot (nxt_slot)
    );

    psw_sp_bank #(.DW(DW)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .cur_slot  (cur_slot),
        .nxt_slot  (nxt_slot),
        .sp_we     (sp_we),
        .sp_wdata  (sp_wdata),
        .sp_q      (sp_q),
        .bank_sel  (bank_sel),
        .bank_we   (bank_we),
        .bank_wdata(bank_wdata),
        .bank_rdata(bank_rdata)
    );

    psw_fc_regs #(.DW(DW), .NFC(2)) u_fc (
        .clk  (clk),
        .rst  (rst),
        .we   ({fcd_we, fcs_we}),
        .wdata(fc_wdata),
        .q    (fc_q)
    );

    assign fcs_q = fc_q[0];
    assign fcd_q = fc_q[1];

    p_never_none_r4: assert property (@(posedge clk) disable iff (rst)
        cur_slot != SLOT_NONE);

endmodule

// File: tb/psw_spbank_tb.sv
module psw_spbank_tb;

    logic        clk = 0;
    logic        rst;
    logic        model_ext;
    logic        sr_we;
    logic [15:0] sr_wdata;
    logic [15:0] sr_q;
    logic        sp_we;
    logic [31:0] sp_wdata;
    logic [31:0] sp_q;
    logic [1:0]  bank_sel;
    logic        bank_we;
    logic [31:0] bank_wdata;
    logic [31:0] bank_rdata;
    logic        fcs_we, fcd_we;
    logic [31:0] fc_wdata;
    logic [2:0]  fcs_q, fcd_q;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [15:0] r_sr;
    logic [31:0] r_live;
    logic [31:0] r_slot [3];
    logic [2:0]  r_fcs, r_fcd;

    always #5 clk = ~clk;

    psw_spbank u_dut (
        .clk(clk), .rst(rst), .model_ext(model_ext),
        .sr_we(sr_we), .sr_wdata(sr_wdata), .sr_q(sr_q),
        .sp_we(sp_we), .sp_wdata(sp_wdata), .sp_q(sp_q),
        .bank_sel(bank_sel), .bank_we(bank_we), .bank_wdata(bank_wdata),
        .bank_rdata(bank_rdata),
        .fcs_we(fcs_we), .fcd_we(fcd_we), .fc_wdata(fc_wdata),
        .fcs_q(fcs_q), .fcd_q(fcd_q)
    );

    function automatic int mode_of(input logic [15:0] s);
        if (!s[13]) return 0;
        return s[12] ? 2 : 1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        sr_we = 0; sp_we = 0; bank_we = 0; fcs_we = 0; fcd_we = 0;
        sr_wdata = 0; sp_wdata = 0; bank_wdata = 0; fc_wdata = 0; bank_sel = 0;
    endtask

    // one clocked operation; inputs set by caller just after a negedge
    task automatic step();
        int cur, nm;
        logic [31:0] nl;
        logic [31:0] ns [3];
        logic [15:0] nsr;
        cur = mode_of(r_sr);
        nl = r_live;
        for (int i = 0; i < 3; i++) ns[i] = r_slot[i];
        nsr = r_sr;
        if (bank_we && bank_sel != 2'd3) begin
            if (int'(bank_sel) == cur) nl = bank_wdata;
            else ns[bank_sel] = bank_wdata;
        end
        if (sp_we) nl = sp_wdata;
        if (sr_we) begin
            nsr = sr_wdata & (model_ext ? 16'hF71F : 16'hA71F);
            nm = mode_of(nsr);
            if (nm != cur) begin
                ns[cur] = nl;
                nl = ns[nm];
            end
        end
        if (fcs_we) r_fcs = fc_wdata[2:0];
        if (fcd_we) r_fcd = fc_wdata[2:0];
        @(posedge clk);
        @(negedge clk);
        r_sr = nsr; r_live = nl;
        for (int i = 0; i < 3; i++) r_slot[i] = ns[i];
        idle_inputs();
    endtask

    task automatic check_all(input string ctx);
        int cur;
        cur = mode_of(r_sr);
        chk({ctx, " R2/R3 sr"}, {16'h0, sr_q}, {16'h0, r_sr});
        chk({ctx, " R4 sp"}, sp_q, r_live);
        for (int i = 0; i < 4; i++) begin
            bank_sel = 2'(i);
            #1;
            if (i == 3)      chk({ctx, " R10 sel3"}, bank_rdata, 32'h0);
            else if (i == cur) chk({ctx, " R6 active"}, bank_rdata, r_live);
            else             chk({ctx, " R7 stored"}, bank_rdata, r_slot[i]);
        end
        bank_sel = 0;
        chk({ctx, " R9 fcs"}, {29'h0, fcs_q}, {29'h0, r_fcs});
        chk({ctx, " R9 fcd"}, {29'h0, fcd_q}, {29'h0, r_fcd});
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        idle_inputs();
        model_ext = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        r_sr = 16'h2000; r_live = 0; r_fcs = 0; r_fcd = 0;
        for (int i = 0; i < 3; i++) r_slot[i] = 0;
        // R1 reset state
        chk("R1 reset sr", {16'h0, sr_q}, 32'h2000);
        chk("R1 reset sp", sp_q, 32'h0);
        check_all("R1");

        // R2 basic mask drops T0 and M
        sr_we = 1; sr_wdata = 16'hFFFF; step();
        chk("R2 basic all-ones", {16'h0, sr_q}, 32'h0000A71F);
        check_all("R2");

        // R6 write active (interrupt) slot through direct port
        sp_we = 1; sp_wdata = 32'h1000_0000; step();
        bank_sel = 2'd1; bank_we = 1; bank_wdata = 32'hAAAA_0001; step();
        chk("R6 direct write active", sp_q, 32'hAAAA_0001);
        // R7 inactive write leaves live
        bank_sel = 2'd0; bank_we = 1; bank_wdata = 32'h0000_5555; step();
        chk("R7 inactive keeps sp", sp_q, 32'hAAAA_0001);
        check_all("R7");

        // R5 swap to user
        sr_we = 1; sr_wdata = 16'h0000; step();
        chk("R5 load user", sp_q, 32'h0000_5555);
        bank_sel = 2'd1; #1;
        chk("R5 saved interrupt", bank_rdata, 32'hAAAA_0001);

        // R3 extended mask, go to master
        model_ext = 1;
        sr_we = 1; sr_wdata = 16'hFFFF; step();
        chk("R3 ext all-ones", {16'h0, sr_q}, 32'h0000F71F);
        chk("R4 master slot", sp_q, 32'h0);
        check_all("R3");

        // R8 sp write with bank write to active, and with mode change
        sp_we = 1; sp_wdata = 32'hBEEF_0000; bank_we = 1; bank_sel = 2'd2;
        bank_wdata = 32'h1111_1111; step();
        chk("R8 sp beats direct", sp_q, 32'hBEEF_0000);
        sp_we = 1; sp_wdata = 32'hCAFE_0002; sr_we = 1; sr_wdata = 16'h2000; step();
        chk("R8 sp into old slot", sp_q, 32'hAAAA_0001);
        bank_sel = 2'd2; #1;
        chk("R8 master saved", bank_rdata, 32'hCAFE_0002);

        // R10 sel 3 write ignored
        bank_sel = 2'd3; bank_we = 1; bank_wdata = 32'hDEAD_DEAD; step();
        check_all("R10");

        // R9 function codes
        fcs_we = 1; fc_wdata = 32'hFFFF_FFFD; step();
        chk("R9 fcs low bits", {29'h0, fcs_q}, 32'h5);
        chk("R9 fcd untouched", {29'h0, fcd_q}, 32'h0);

        // random mix
        for (int k = 0; k < 400; k++) begin
            model_ext  = ($urandom % 4) != 0;
            sr_we      = ($urandom % 3) == 0;
            sr_wdata   = 16'($urandom);
            sp_we      = ($urandom % 4) == 0;
            sp_wdata   = $urandom;
            bank_we    = ($urandom % 2) == 0;
            bank_sel   = 2'($urandom);
            bank_wdata = $urandom;
            fcs_we     = ($urandom % 4) == 0;
            fcd_we     = ($urandom % 4) == 0;
            fc_wdata   = $urandom;
            step();
            check_all("RND");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule